// File: doc/BRIEF.md
# Message-Signaled Interrupt Aggregator

This block collects message-signaled interrupt vectors that arrive as plain register writes and fans them out to one interrupt line per processor core. A vector is written to a single trigger register. Its low three bits choose one of eight groups, and its next two bits choose one of four pending bits inside that group. Consecutive vectors therefore land in different groups, and vectors 0, 8, 16 and 24 all share group 0.

Each group has a raw pending view, a view masked by the group's enable bits, separate registers to set and clear the enable bits, and its own interrupt output. An output gives a single-cycle pulse and then stays quiet until software writes that group's end-of-interrupt code. If work is still pending at that point, the output pulses again at once. The bus is a simple 32-bit word interface. Writes take effect on the clock edge where the write strobe is high. Read data is a combinational function of the address.

Top module: `msi_irq_aggregator`

## Requirements
- R1: A write of value w to byte offset 0x54 takes v = w[4:0] and sets raw bit (v / 8) of group (v mod 8). Bits w[31:5] are ignored, and offset 0x54 reads as 0.
- R2: Group n uses four word registers at 0x100 + 0x10·n: raw at +0x0, masked at +0x4, enable-set at +0x8 and enable-clear at +0xC. Values sit in bits [3:0] and bits [31:4] read 0. Any other offset reads 0.
- R3: A raw bit sets on a trigger write whatever the group's enable mask is.
- R4: The masked register reads raw AND enable for its group.
- R5: Writing a value to a group's masked register clears the raw bits where that value has a 1 and leaves the other bits alone. Writes to the raw register have no effect.
- R6: A 1 written to enable-set sets that enable bit. A 1 written to enable-clear clears it. Zeros have no effect. Both offsets read back the current enable mask.
- R7: If group n is armed and its masked status is non-zero in a cycle, irq_o[n] is high for exactly the next cycle and the group is disarmed. The other outputs are not affected.
- R8: A write of 4 + n (n = 0..7) to offset 0x50 re-arms group n. If its masked status is non-zero, it pulses again one cycle later. Values outside 4..11 are ignored. If a pulse and the end-of-interrupt write fall in the same cycle, the group ends up disarmed.
- R9: After reset all raw bits and all enables are 0, every group is armed, and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 8 | One interrupt pulse line per group |

## Verification
Vectors are sent with the enables off, then with the enables on. This separates the raw view from the masked view, and it shows that a pulse waits for the mask rather than for the trigger. Pulses are tested in several ways: repeated triggers while a group is disarmed, end-of-interrupt writes with work still pending and with none pending, and codes just outside the valid range. Together these show that one output per group is re-armed, and only by its own code. A sweep over all 32 vectors with junk in the upper data bits checks the interleaved decode. Clearing through both write-1 paths, and writing to the read-only raw view, shows which bits each write may touch.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int unsigned EOI_OFS     = 32'h050;
  localparam int unsigned TRIG_OFS    = 32'h054;
  localparam int unsigned GRP_BASE    = 32'h100;
  localparam int unsigned GRP_STRIDE  = 32'h010;
  localparam int unsigned STRIDE_SH   = 4;
  localparam int unsigned EOI_FIRST   = 4;

  typedef enum logic [1:0] {
    KIND_RAW    = 2'd0,
    KIND_MASKED = 2'd1,
    KIND_EN_SET = 2'd2,
    KIND_EN_CLR = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/msi_bus_decode.sv
module msi_bus_decode
  import msi_agg_pkg::*;
#(
  parameter int unsigned NUM_GROUPS     = 8,
  parameter int unsigned BITS_PER_GROUP = 4,
  parameter int unsigned ADDR_W         = 12,
  parameter int unsigned DATA_W         = 32,
  localparam int unsigned TOT_W = NUM_GROUPS * BITS_PER_GROUP,
  localparam int unsigned GRP_W = $clog2(NUM_GROUPS),
  localparam int unsigned BIT_W = $clog2(BITS_PER_GROUP),
  localparam int unsigned VEC_W = GRP_W + BIT_W
) (
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [TOT_W-1:0]    set_bits,
  output logic [TOT_W-1:0]    clr_bits,
  output logic [TOT_W-1:0]    en_set_bits,
  output logic [TOT_W-1:0]    en_clr_bits,
  output logic [NUM_GROUPS-1:0] eoi_hit,
  output logic                grp_hit,
  output logic [GRP_W-1:0]    grp_idx,
  output reg_kind_e           grp_kind
);
  logic [ADDR_W-1:0] grp_off;
  logic [GRP_W-1:0]  vec_grp;
  logic [BIT_W-1:0]  vec_bit;
  logic [DATA_W-1:0] eoi_rel;
  logic              eoi_ok;

  always_comb begin
    grp_off  = bus_addr - ADDR_W'(GRP_BASE);
    grp_hit  = (bus_addr >= ADDR_W'(GRP_BASE)) &&
               (bus_addr <  ADDR_W'(GRP_BASE + NUM_GROUPS * GRP_STRIDE)) &&
               (bus_addr[1:0] == 2'b00);
    grp_idx  = grp_off[STRIDE_SH +: GRP_W];
    grp_kind = reg_kind_e'(grp_off[3:2]);

    vec_grp  = bus_wdata[GRP_W-1:0];
    vec_bit  = bus_wdata[VEC_W-1:GRP_W];
    eoi_rel  = bus_wdata - DATA_W'(EOI_FIRST);
    eoi_ok   = (bus_wdata >= DATA_W'(EOI_FIRST)) &&
               (bus_wdata <  DATA_W'(EOI_FIRST + NUM_GROUPS));

    set_bits    = '0;
    clr_bits    = '0;
    en_set_bits = '0;
    en_clr_bits = '0;
    eoi_hit     = '0;

    if (bus_we) begin
      if (bus_addr == ADDR_W'(TRIG_OFS)) begin
        set_bits = TOT_W'(1) << {vec_grp, vec_bit};
      end
      if ((bus_addr == ADDR_W'(EOI_OFS)) && eoi_ok) begin
        eoi_hit = NUM_GROUPS'(1) << eoi_rel[GRP_W-1:0];
      end
      if (grp_hit) begin
        unique case (grp_kind)
          KIND_MASKED: clr_bits[grp_idx*BITS_PER_GROUP +: BITS_PER_GROUP]    = bus_wdata[BITS_PER_GROUP-1:0];
          KIND_EN_SET: en_set_bits[grp_idx*BITS_PER_GROUP +: BITS_PER_GROUP] = bus_wdata[BITS_PER_GROUP-1:0];
          KIND_EN_CLR: en_clr_bits[grp_idx*BITS_PER_GROUP +: BITS_PER_GROUP] = bus_wdata[BITS_PER_GROUP-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/msi_group.sv
module msi_group #(
  parameter int unsigned BITS_PER_GROUP = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BITS_PER_GROUP-1:0] set_bits,
  input  logic [BITS_PER_GROUP-1:0] clr_bits,
  input  logic [BITS_PER_GROUP-1:0] en_set_bits,
  input  logic [BITS_PER_GROUP-1:0] en_clr_bits,
  input  logic                      eoi,
  output logic [BITS_PER_GROUP-1:0] raw_q,
  output logic [BITS_PER_GROUP-1:0] en_q,
  output logic                      irq_q
);
  logic [BITS_PER_GROUP-1:0] raw_d, en_d, masked;
  logic raw_upd, en_upd, fire, armed_q, armed_d;

  // next-state
  always_comb begin
    raw_d   = (raw_q & ~clr_bits) | set_bits;
    raw_upd = (|set_bits) | (|clr_bits);
    en_d    = (en_q | en_set_bits) & ~en_clr_bits;
    en_upd  = (|en_set_bits) | (|en_clr_bits);
    masked  = raw_q & en_q;
    fire    = armed_q & (|masked);
    armed_d = fire ? 1'b0 : (armed_q | eoi);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      en_q    <= '0;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      if (raw_upd) raw_q <= raw_d;
      if (en_upd)  en_q  <= en_d;
      armed_q <= armed_d;
      irq_q   <= fire;
    end
  end
endmodule

// File: rtl/msi_read_mux.sv
module msi_read_mux
  import msi_agg_pkg::*;
#(
  parameter int unsigned NUM_GROUPS     = 8,
  parameter int unsigned BITS_PER_GROUP = 4,
  parameter int unsigned DATA_W         = 32,
  localparam int unsigned TOT_W = NUM_GROUPS * BITS_PER_GROUP,
  localparam int unsigned GRP_W = $clog2(NUM_GROUPS)
) (
  input  logic              grp_hit,
  input  logic [GRP_W-1:0]  grp_idx,
  input  reg_kind_e         grp_kind,
  input  logic [TOT_W-1:0]  raw_all,
  input  logic [TOT_W-1:0]  en_all,
  output logic [DATA_W-1:0] rdata
);
  logic [BITS_PER_GROUP-1:0] raw_sel, en_sel;

  always_comb begin
    raw_sel = raw_all[grp_idx*BITS_PER_GROUP +: BITS_PER_GROUP];
    en_sel  = en_all[grp_idx*BITS_PER_GROUP +: BITS_PER_GROUP];
    rdata   = '0;
    if (grp_hit) begin
      unique case (grp_kind)
        KIND_RAW:    rdata[BITS_PER_GROUP-1:0] = raw_sel;
        KIND_MASKED: rdata[BITS_PER_GROUP-1:0] = raw_sel & en_sel;
        default:     rdata[BITS_PER_GROUP-1:0] = en_sel;
      endcase
    end
  end
endmodule

// File: rtl/msi_irq_aggregator.sv
module msi_irq_aggregator
  import msi_agg_pkg::*;
#(
  parameter int unsigned NUM_GROUPS     = 8,
  parameter int unsigned BITS_PER_GROUP = 4,
  parameter int unsigned ADDR_W         = 12,
  parameter int unsigned DATA_W         = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NUM_GROUPS-1:0] irq_o
);
  localparam int unsigned TOT_W = NUM_GROUPS * BITS_PER_GROUP;
  localparam int unsigned GRP_W = $clog2(NUM_GROUPS);

  logic [1:0]            rst_sync_q;
  logic                  rst_int_n;
  logic [TOT_W-1:0]      set_bits, clr_bits, en_set_bits, en_clr_bits;
  logic [TOT_W-1:0]      raw_all, en_all;
  logic [NUM_GROUPS-1:0] eoi_hit;
  logic                  grp_hit;
  logic [GRP_W-1:0]      grp_idx;
  reg_kind_e             grp_kind;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  msi_bus_decode #(
    .NUM_GROUPS(NUM_GROUPS), .BITS_PER_GROUP(BITS_PER_GROUP),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_decode (
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .set_bits(set_bits), .clr_bits(clr_bits),
    .en_set_bits(en_set_bits), .en_clr_bits(en_clr_bits),
    .eoi_hit(eoi_hit), .grp_hit(grp_hit), .grp_idx(grp_idx),
    .grp_kind(grp_kind)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    msi_group #(.BITS_PER_GROUP(BITS_PER_GROUP)) u_group (
      .clk(clk), .rst_n(rst_int_n),
      .set_bits(set_bits[g*BITS_PER_GROUP +: BITS_PER_GROUP]),
      .clr_bits(clr_bits[g*BITS_PER_GROUP +: BITS_PER_GROUP]),
      .en_set_bits(en_set_bits[g*BITS_PER_GROUP +: BITS_PER_GROUP]),
      .en_clr_bits(en_clr_bits[g*BITS_PER_GROUP +: BITS_PER_GROUP]),
      .eoi(eoi_hit[g]),
      .raw_q(raw_all[g*BITS_PER_GROUP +: BITS_PER_GROUP]),
      .en_q(en_all[g*BITS_PER_GROUP +: BITS_PER_GROUP]),
      .irq_q(irq_o[g])
    );
  end

  msi_read_mux #(
    .NUM_GROUPS(NUM_GROUPS), .BITS_PER_GROUP(BITS_PER_GROUP), .DATA_W(DATA_W)
  ) u_rmux (
    .grp_hit(grp_hit), .grp_idx(grp_idx), .grp_kind(grp_kind),
    .raw_all(raw_all), .en_all(en_all), .rdata(bus_rdata)
  );
endmodule

// File: rtl/msi_agg_checks.sv
module msi_agg_checks
  import msi_agg_pkg::*;
#(
  parameter int unsigned NUM_GROUPS     = 8,
  parameter int unsigned BITS_PER_GROUP = 4,
  parameter int unsigned ADDR_W         = 12,
  parameter int unsigned DATA_W         = 32,
  localparam int unsigned TOT_W = NUM_GROUPS * BITS_PER_GROUP,
  localparam int unsigned GRP_W = $clog2(NUM_GROUPS),
  localparam int unsigned VEC_W = GRP_W + $clog2(BITS_PER_GROUP)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_we,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic [NUM_GROUPS-1:0] irq_o,
  input logic [TOT_W-1:0]      raw_all,
  input logic [TOT_W-1:0]      en_all
);
  // R1
  trig_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(TRIG_OFS)) |=>
      raw_all[{$past(bus_wdata[GRP_W-1:0]), $past(bus_wdata[VEC_W-1:GRP_W])}]);

  // R1
  trig_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(TRIG_OFS)) |-> (bus_rdata == '0));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    // R7
    irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |=> !irq_o[g]);

    // R6
    en_clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(GRP_BASE + g*GRP_STRIDE + 12)) |=>
        ((en_all[g*BITS_PER_GROUP +: BITS_PER_GROUP] &
          $past(bus_wdata[BITS_PER_GROUP-1:0])) == '0));

    // R4
    masked_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(GRP_BASE + g*GRP_STRIDE + 4)) |->
        (bus_rdata == DATA_W'(raw_all[g*BITS_PER_GROUP +: BITS_PER_GROUP] &
                              en_all[g*BITS_PER_GROUP +: BITS_PER_GROUP])));
  end
endmodule

bind msi_irq_aggregator msi_agg_checks #(
  .NUM_GROUPS(NUM_GROUPS), .BITS_PER_GROUP(BITS_PER_GROUP),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_checks (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
  .raw_all(raw_all), .en_all(en_all)
);

// File: tb/test_msi_irq_aggregator.sv
module test_msi_irq_aggregator;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural reference state
  int m_raw[8];
  int m_en[8];
  bit m_armed[8];
  bit m_irq[8];
  int pulse_cnt[8];

  always #(PERIOD/2) clk = ~clk;

  msi_irq_aggregator i_msi_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < 8; g++) begin
        m_raw[g] = 0; m_en[g] = 0; m_armed[g] = 1; m_irq[g] = 0;
      end
    end else begin
      bit eoi[8];
      for (int g = 0; g < 8; g++) eoi[g] = 0;
      if (bus_we && bus_addr == 12'h050 && bus_wdata >= 4 && bus_wdata <= 11)
        eoi[bus_wdata - 4] = 1;
      for (int g = 0; g < 8; g++) begin
        bit f;
        f = m_armed[g] && ((m_raw[g] & m_en[g]) != 0);
        m_irq[g] = f;
        if (f) m_armed[g] = 0;
        else if (eoi[g]) m_armed[g] = 1;
      end
      if (bus_we) begin
        if (bus_addr == 12'h054) begin
          int v;
          v = bus_wdata % 32;
          m_raw[v % 8] = m_raw[v % 8] | (1 << (v / 8));
        end else if (bus_addr >= 12'h100 && bus_addr < 12'h180 && bus_addr % 4 == 0) begin
          int g, k, d;
          g = (bus_addr - 12'h100) / 16;
          k = (bus_addr % 16) / 4;
          d = bus_wdata % 16;
          if (k == 1) m_raw[g] = m_raw[g] & ~d;
          if (k == 2) m_en[g]  = m_en[g] | d;
          if (k == 3) m_en[g]  = m_en[g] & ~d;
        end
      end
    end
  end

  function automatic int exp_read(input int a);
    int g, k;
    if (a >= 'h100 && a < 'h180 && a % 4 == 0) begin
      g = (a - 'h100) / 16;
      k = (a % 16) / 4;
      if (k == 0) return m_raw[g];
      if (k == 1) return m_raw[g] & m_en[g];
      return m_en[g];
    end
    return 0;
  endfunction

  function automatic string tag_of(input int a);
    if (a == 'h54) return "R1";
    if (a >= 'h100 && a < 'h180 && a % 4 == 0) begin
      if ((a % 16) / 4 == 0) return "R3";
      if ((a % 16) / 4 == 1) return "R4";
      return "R6";
    end
    return "R2";
  endfunction

  // compare every cycle against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e;
      for (int g = 0; g < 8; g++) begin
        n_cmp++;
        if (irq_o[g] !== m_irq[g]) begin
          n_bad++;
          $display("FAIL R7 irq_o[%0d] actual %b expected %b at %0t", g, irq_o[g], m_irq[g], $time);
        end
        if (irq_o[g] === 1'b1) pulse_cnt[g]++;
      end
      e = exp_read(int'(bus_addr));
      n_cmp++;
      if (bus_rdata !== 32'(e)) begin
        n_bad++;
        $display("FAIL %s read 0x%03h actual 0x%08h expected 0x%08h", tag_of(int'(bus_addr)), bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = 12'(a); bus_wdata = 32'(d);
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic peek(input int a, input int exp, input string tag);
    @(posedge clk); #1;
    bus_we = 1'b0; bus_addr = 12'(a);
    @(negedge clk);
    chk(int'(bus_rdata), exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    for (int g = 0; g < 8; g++) pulse_cnt[g] = 0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R9 reset state
    chk(int'(irq_o), 0, "R9 irq");
    for (int g = 0; g < 8; g++) begin
      peek('h100 + 16*g, 0, "R9 raw");
      peek('h108 + 16*g, 0, "R9 enable");
    end
    peek('h030, 0, "R2 unmapped");

    // R3: trigger with enables off
    wr('h54, 0);
    peek('h100, 1, "R3 raw set while disabled");
    peek('h104, 0, "R4 masked zero while disabled");
    idle(3);
    chk(pulse_cnt[0], 0, "R7 no pulse while disabled");

    // R6/R7: enable group 0, expect one pulse
    wr('h108, 'hF);
    idle(4);
    chk(pulse_cnt[0], 1, "R7 first pulse");
    wr('h54, 8); wr('h54, 16); wr('h54, 24);
    idle(4);
    chk(pulse_cnt[0], 1, "R7 disarmed no repeat");
    peek('h104, 'hF, "R4 masked all four");

    // R5: raw register is read-only, masked W1C
    wr('h100, 'hF);
    peek('h100, 'hF, "R5 raw write ignored");
    wr('h104, 'h3);
    peek('h100, 'hC, "R5 w1c cleared low bits");

    // R8: invalid EOI codes, then the right one with work pending
    wr('h50, 3); wr('h50, 12); wr('h50, 'h104); wr('h50, 5);
    idle(4);
    chk(pulse_cnt[0], 1, "R8 wrong codes ignored");
    wr('h50, 4);
    idle(4);
    chk(pulse_cnt[0], 2, "R8 re-pulse on eoi");
    wr('h104, 'hC);
    wr('h50, 4);
    idle(4);
    chk(pulse_cnt[0], 2, "R8 eoi with nothing pending");

    // R1: sweep all vectors with junk upper bits, enables off elsewhere
    for (int v = 0; v < 32; v++) wr('h54, 32'hFFFF_FFE0 | v);
    for (int g = 0; g < 8; g++) peek('h100 + 16*g, 'hF, "R1 sweep raw");
    peek('h54, 0, "R1 trigger reads zero");
    chk(pulse_cnt[0], 3, "R7 group 0 pulses again");
    chk(pulse_cnt[1], 0, "R7 group 1 silent");

    // R6: enable set/clear on group 3
    wr('h138, 'h5);
    peek('h13C, 'h5, "R6 enable via clear offset");
    idle(3);
    chk(pulse_cnt[3], 1, "R7 group 3 pulse");
    wr('h13C, 'h4);
    peek('h138, 'h1, "R6 enable cleared");
    peek('h134, 'h1, "R4 masked after clear");
    wr('h13C, 'h0);
    peek('h138, 'h1, "R6 zero clear no effect");
    wr('h134, 'h1);
    wr('h50, 7);
    idle(4);
    chk(pulse_cnt[3], 1, "R8 group 3 eoi nothing pending");
    wr('h54, 3);
    idle(4);
    chk(pulse_cnt[3], 2, "R7 group 3 rearmed pulse");

    idle(5);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule